// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a serial chain of N test cells placed between a chip's core logic and its package pins. Each cell watches one signal: an output cell sits on a core-to-pin path and an input cell sits on a pin-to-core path. A per-cell parameter mask chooses the kind. Every cell has a capture multiplexer, a shift flip-flop linked to its neighbours, an update flip-flop and an output multiplexer. Capture, shift and update strobes come from the test access port controller. A three-bit mode code comes from the instruction decoder.

The shift stage and the update stage are separate flip-flops. Capturing and shifting therefore never disturb the signals the cells drive until an explicit update strobe. The mode code is decoded into three controls: whether the chain is the selected serial path, whether output cells drive pins from their update stage, and whether input cells drive the core from their update stage. The modes behave as decode states that the code may change on any test-clock cycle, and every move between them is direct:
- NORMAL (code 0, and the unused codes 5 to 7): transparent operation, chain deselected.
- SAMPLE (code 1): sampling and preloading, transparent.
- EXTEST (code 2): output cells drive the pins.
- INTEST (code 3): input cells drive the core.
- CLAMP (code 4): output cells drive the pins, chain deselected.

The shift flip-flops act on the rising test-clock edge. The update flip-flops load on the falling edge.

Top module: `bsc_chain`

## Requirements
- R1: After reset (rst_n low) every shift and update flip-flop holds 0, so scan_out is 0 and, in EXTEST, every output cell drives 0.
- R2: With mode code 0, or any unused code 5 to 7, par_out equals par_in for every cell. Capture, shift and update strobes leave the chain contents unchanged.
- R3: In modes 1, 2 and 3, capture_en at a rising tck edge loads par_in[i] into the shift flip-flop of cell i.
- R4: In modes 1, 2 and 3, shift_en at a rising tck edge moves each cell's shift value to cell i-1. scan_in enters cell N-1, and scan_out always shows cell 0. Shifting N bits in, least significant first, leaves bit i in cell i and shifts the old contents out, least significant first.
- R5: In modes 1, 2 and 3, update_en at a falling tck edge copies every shift flip-flop into its update flip-flop.
- R6: Update flip-flops keep their values across capture and shift and change only on an update strobe.
- R7: In mode 1 (SAMPLE), par_out equals par_in for every cell, whatever the update contents. Values preloaded there appear when a driving mode is later selected.
- R8: In mode 2 (EXTEST), output cells (OUT_MASK bit 1) drive their update value on par_out, and input cells pass par_in through.
- R9: In mode 3 (INTEST), input cells (OUT_MASK bit 0) drive their update value on par_out, and output cells pass par_in through.
- R10: In mode 4 (CLAMP), output cells drive their update value and input cells pass par_in through. Capture, shift and update strobes leave both stages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset of both stages |
| capture_en | input | 1 | Capture strobe from the access-port controller |
| shift_en | input | 1 | Shift strobe from the access-port controller |
| update_en | input | 1 | Update strobe, acted on at the falling edge |
| mode | input | 3 | Test mode code from the instruction decoder |
| scan_in | input | 1 | Serial input from the previous stage |
| scan_out | output | 1 | Serial output to the next stage (cell 0) |
| par_in | input | N | Per-cell parallel input: the core value for output cells, the pin value for input cells |
| par_out | output | N | Per-cell parallel output: the pin for output cells, the core input for input cells |

## Verification
The assertions assume that the access-port controller raises at most one of capture, shift and update in any cycle. One property checks this assumption. The bench pulses exactly one strobe at a time through its tasks. The assertions also assume that mode and the strobes change only away from clock edges. The bench drives every input just after a rising edge, so the falling-edge update sees steady controls. Sweeps run all 256 parallel patterns through capture and through EXTEST update. Spot patterns cover INTEST, CLAMP, preload and the unused codes.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL = 3'd0,
        MODE_SAMPLE = 3'd1,
        MODE_EXTEST = 3'd2,
        MODE_INTEST = 3'd3,
        MODE_CLAMP  = 3'd4
    } bsc_mode_e;

    typedef struct packed {
        logic chain_sel;
        logic drv_pin;
        logic drv_core;
    } bsc_ctl_t;

endpackage

// File: rtl/bsc_mode_dec.sv
module bsc_mode_dec
    import bsc_pkg::*;
(
    input  logic [2:0] mode_code,
    output bsc_ctl_t   ctl
);

    always_comb begin
        ctl = '0;
        unique case (mode_code)
            MODE_SAMPLE: ctl.chain_sel = 1'b1;
            MODE_EXTEST: begin
                ctl.chain_sel = 1'b1;
                ctl.drv_pin   = 1'b1;
            end
            MODE_INTEST: begin
                ctl.chain_sel = 1'b1;
                ctl.drv_core  = 1'b1;
            end
            MODE_CLAMP:  ctl.drv_pin = 1'b1;
            default:     ctl = '0;
        endcase
    end

endmodule

// File: rtl/bsc_cell.sv
module bsc_cell #(
    parameter bit IS_OUTPUT = 1'b1
) (
    input  logic tck,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shf_en,
    input  logic upd_en,
    input  logic drv_pin,
    input  logic drv_core,
    input  logic ser_in,
    input  logic par_in,
    output logic par_out,
    output logic shf_q,
    output logic upd_q
);

    logic drive;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)      shf_q <= 1'b0;
        else if (cap_en) shf_q <= par_in;
        else if (shf_en) shf_q <= ser_in;
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n)      upd_q <= 1'b0;
        else if (upd_en) upd_q <= shf_q;
    end

    generate
        if (IS_OUTPUT) begin : g_out
            assign drive = drv_pin;
        end else begin : g_in
            assign drive = drv_core;
        end
    endgenerate

    assign par_out = drive ? upd_q : par_in;

endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
    import bsc_pkg::*;
#(
    parameter int            N        = 8,
    parameter logic [N-1:0]  OUT_MASK = N'(8'h0F)
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         capture_en,
    input  logic         shift_en,
    input  logic         update_en,
    input  logic [2:0]   mode,
    input  logic         scan_in,
    output logic         scan_out,
    input  logic [N-1:0] par_in,
    output logic [N-1:0] par_out
);

    localparam int LINK_W = N + 1;

    bsc_ctl_t           ctl;
    logic               cap_g;
    logic               shf_g;
    logic               upd_g;
    logic [LINK_W-1:0]  link;
    logic [N-1:0]       shf_vec;
    logic [N-1:0]       upd_vec;

    bsc_mode_dec dec_i (
        .mode_code (mode),
        .ctl       (ctl)
    );

    assign cap_g = capture_en & ctl.chain_sel;
    assign shf_g = shift_en   & ctl.chain_sel;
    assign upd_g = update_en  & ctl.chain_sel;

    assign link[N]     = scan_in;
    assign link[N-1:0] = shf_vec;
    assign scan_out    = link[0];

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            bsc_cell #(.IS_OUTPUT(OUT_MASK[i])) cell_i (
                .tck      (tck),
                .rst_n    (rst_n),
                .cap_en   (cap_g),
                .shf_en   (shf_g),
                .upd_en   (upd_g),
                .drv_pin  (ctl.drv_pin),
                .drv_core (ctl.drv_core),
                .ser_in   (link[i+1]),
                .par_in   (par_in[i]),
                .par_out  (par_out[i]),
                .shf_q    (shf_vec[i]),
                .upd_q    (upd_vec[i])
            );
        end
    endgenerate

endmodule

// File: rtl/bsc_chain_chk.sv
module bsc_chain_chk #(
    parameter int           N        = 8,
    parameter logic [N-1:0] OUT_MASK = N'(8'h0F)
) (
    input logic         tck,
    input logic         rst_n,
    input logic         capture_en,
    input logic         shift_en,
    input logic         update_en,
    input logic [2:0]   mode,
    input logic         scan_in,
    input logic         scan_out,
    input logic [N-1:0] par_in,
    input logic [N-1:0] par_out,
    input logic [N-1:0] shf_vec,
    input logic [N-1:0] upd_vec
);

    logic sel;
    logic pass_mode;
    assign sel       = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd3);
    assign pass_mode = (mode == 3'd0) || (mode >= 3'd5);

    p_ctl_excl_r3: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({capture_en, shift_en, update_en}));

    p_capture_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (capture_en && sel) |=> (shf_vec == $past(par_in)));

    p_shift_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_en && !capture_en && sel) |=>
            (shf_vec == {$past(scan_in), $past(shf_vec[N-1:1])}));

    p_scanout_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_en && !capture_en && sel) |=> (scan_out == $past(shf_vec[1])));

    p_idle_r10: assert property (@(posedge tck) disable iff (!rst_n)
        !(sel && (capture_en || shift_en)) |=> $stable(shf_vec));

    p_upd_hold_r6: assert property (@(negedge tck) disable iff (!rst_n)
        !(update_en && sel) |=> $stable(upd_vec));

    p_pass_r2: assert property (@(posedge tck) disable iff (!rst_n)
        pass_mode |-> (par_out == par_in));

    p_sample_r7: assert property (@(posedge tck) disable iff (!rst_n)
        (mode == 3'd1) |-> (par_out == par_in));

    p_extest_r8: assert property (@(posedge tck) disable iff (!rst_n)
        (mode == 3'd2) |-> ((((par_out ^ upd_vec) & OUT_MASK) == '0) &&
                            (((par_out ^ par_in) & ~OUT_MASK) == '0)));

    p_intest_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (mode == 3'd3) |-> ((((par_out ^ upd_vec) & ~OUT_MASK) == '0) &&
                            (((par_out ^ par_in) & OUT_MASK) == '0)));

    p_clamp_r10: assert property (@(posedge tck) disable iff (!rst_n)
        (mode == 3'd4) |-> ((((par_out ^ upd_vec) & OUT_MASK) == '0) &&
                            (((par_out ^ par_in) & ~OUT_MASK) == '0)));

endmodule

bind bsc_chain bsc_chain_chk #(.N(N), .OUT_MASK(OUT_MASK)) chk_i (
    .tck        (tck),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .mode       (mode),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .par_in     (par_in),
    .par_out    (par_out),
    .shf_vec    (shf_vec),
    .upd_vec    (upd_vec)
);

// File: tb/bsc_chain_tb_top.sv
`timescale 1ns/1ps
module bsc_chain_tb_top;

    localparam int           N    = 8;
    localparam logic [N-1:0] MASK = 8'h0F;

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         capture_en = 1'b0;
    logic         shift_en = 1'b0;
    logic         update_en = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         scan_in = 1'b0;
    logic         scan_out;
    logic [N-1:0] par_in = '0;
    logic [N-1:0] par_out;

    int checks = 0;
    int errors = 0;

    always #2 tck = ~tck;

    bsc_chain #(.N(N), .OUT_MASK(MASK)) dut_i (
        .tck(tck), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .mode(mode), .scan_in(scan_in), .scan_out(scan_out),
        .par_in(par_in), .par_out(par_out)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        #0.5;
    endtask

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    task automatic shift_word(input logic [N-1:0] v, output logic [N-1:0] got);
        shift_en = 1'b1;
        for (int k = 0; k < N; k++) begin
            scan_in = v[k];
            got[k]  = scan_out;
            tick();
        end
        shift_en = 1'b0;
    endtask

    task automatic pulse_update();
        update_en = 1'b1;
        tick();
        update_en = 1'b0;
    endtask

    task automatic pulse_capture();
        capture_en = 1'b1;
        tick();
        capture_en = 1'b0;
    endtask

    function automatic logic [N-1:0] mix(input logic [N-1:0] drv_bits, input logic [N-1:0] upd, input logic [N-1:0] pin);
        return (upd & drv_bits) | (pin & ~drv_bits);
    endfunction

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] got;
        logic [N-1:0] prev;
        tick();
        tick();
        rst_n = 1'b1;
        // R1: reset state
        par_in = 8'hA5;
        settle();
        check("R1 normal after reset", par_out, 8'hA5);
        check("R1 scan_out after reset", {7'd0, scan_out}, 8'h00);
        mode = 3'd2;
        settle();
        check("R1 extest drives reset update", par_out, mix(MASK, 8'h00, 8'hA5));

        // R2: normal and unused codes pass through and ignore strobes
        for (int p = 0; p < 256; p += 37) begin
            mode = 3'd0; par_in = p[N-1:0];
            settle();
            check("R2 normal pass", par_out, p[N-1:0]);
            mode = 3'd6;
            settle();
            check("R2 unused code pass", par_out, p[N-1:0]);
        end
        mode = 3'd0; par_in = 8'h77;
        pulse_capture();
        shift_word(8'hE1, got);
        pulse_update();
        mode = 3'd2;
        settle();
        check("R2 update ignored in normal", par_out, mix(MASK, 8'h00, 8'h77));
        mode = 3'd1;
        shift_word(8'h00, got);
        check("R2 chain untouched in normal", got, 8'h00);

        // R3: exhaustive capture in sample mode, read back by shifting
        mode = 3'd1;
        for (int p = 0; p < 256; p++) begin
            par_in = p[N-1:0];
            pulse_capture();
            shift_word(p[N-1:0] ^ 8'h3C, got);
            check("R3 capture pattern", got, p[N-1:0]);
        end

        // R4: shift order, scan_in reaches scan_out after N bits
        shift_word(8'h96, got);
        shift_word(8'h01, got);
        check("R4 shift-through 96", got, 8'h96);
        shift_word(8'h80, got);
        check("R4 shift-through 01", got, 8'h01);
        settle();
        check("R4 scan_out shows cell 0", {7'd0, scan_out}, 8'h00);

        // R5/R8: exhaustive extest update sweep
        mode = 3'd2;
        prev = 8'h00;
        shift_word(8'h00, got);
        pulse_update();
        for (int u = 0; u < 256; u++) begin
            par_in = ~u[N-1:0];
            shift_word(u[N-1:0], got);
            settle();
            check("R5 no change before update", par_out, mix(MASK, prev, ~u[N-1:0]));
            pulse_update();
            settle();
            check("R8 extest drives update", par_out, mix(MASK, u[N-1:0], ~u[N-1:0]));
            prev = u[N-1:0];
        end

        // R6: update holds across capture and shift
        shift_word(8'h5A, got);
        pulse_update();
        par_in = 8'hFF;
        pulse_capture();
        settle();
        check("R6 hold across capture", par_out, mix(MASK, 8'h5A, 8'hFF));
        shift_word(8'h00, got);
        check("R6 capture seen in chain", got, 8'hFF);
        check("R6 hold across shift", par_out, mix(MASK, 8'h5A, 8'hFF));
        pulse_update();
        settle();
        check("R6 change on update", par_out, mix(MASK, 8'h00, 8'hFF));

        // R9: intest drives core side
        mode = 3'd3;
        for (int v = 5; v < 256; v += 50) begin
            par_in = v[N-1:0] ^ 8'hF0;
            shift_word(v[N-1:0], got);
            pulse_update();
            settle();
            check("R9 intest drives core", par_out, mix(~MASK, v[N-1:0], v[N-1:0] ^ 8'hF0));
        end

        // R7: sample transparent, preload shows in extest
        mode = 3'd1;
        par_in = 8'h3E;
        shift_word(8'hC3, got);
        pulse_update();
        settle();
        check("R7 sample transparent", par_out, 8'h3E);
        mode = 3'd2;
        settle();
        check("R7 preload applied in extest", par_out, mix(MASK, 8'hC3, 8'h3E));

        // R10: clamp holds pins and ignores chain strobes
        mode = 3'd4;
        par_in = 8'h81;
        settle();
        check("R10 clamp drives preload", par_out, mix(MASK, 8'hC3, 8'h81));
        par_in = 8'h18;
        pulse_capture();
        shift_word(8'h11, got);
        pulse_update();
        settle();
        check("R10 clamp ignores strobes", par_out, mix(MASK, 8'hC3, 8'h18));
        mode = 3'd1;
        shift_word(8'h00, got);
        check("R10 chain kept in clamp", got, 8'hC3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule